// File: doc/BRIEF.md
# Boot Table Section Loader

The loader takes a stream of 32-bit words, moved with a valid/ready handshake, that holds a boot table: a run of sections, each led by a two-word header, then its payload. Each header gives the payload length in bytes and the word-aligned destination address. The loader turns every payload word into one write on a simple memory port carrying address, data, per-lane byte enables and a valid/ready pair. A header whose length word is zero ends the table.

The table arrives big-endian: the first byte of every word sits in bits [31:24]. A swap input reverses the byte order of payload words for a little-endian memory. A mode input picks between a plain section table and a general-purpose-header table. In the second form, once the table ends, the loader presents the base address of the last section as the entry point. A misaligned destination stops the loader with an error flag.

Top module: `boot_section_loader`

## Requirements
- R1: A header is two stream words, taken as unsigned 32-bit values: first the byte count, then the destination address.
- R2: A count word of zero ends the table. `done` is high from the cycle after that word is accepted, and `in_ready` stays low from then on.
- R3: A section with byte count C produces exactly ceil(C/4) writes. They go to the destination address, then +4, +8 and so on, one write for each payload word, in stream order.
- R4: A section whose count leaves n = C mod 4 bytes (n in 1..3) in its last word writes that word with only the n leading lanes enabled. This is lanes [n-1:0] (mask (1<<n)-1) when `swap_le` is 1, and the top n lanes (e.g. 4'b1000 for n=1) when `swap_le` is 0. All other writes have `wr_be` = 4'hF. The next stream word after a partial word is the next header.
- R5: With `swap_le` = 0, `wr_data` equals the stream word. With `swap_le` = 1, byte k of the stream word (bits [31-8k:24-8k]) lands in `wr_data[8k+7:8k]`.
- R6: While `wr_valid` is high and `wr_ready` is low, `in_ready` is low and `wr_addr`, `wr_data` and `wr_be` hold. No payload word is lost or repeated.
- R7: When `gph_mode` is 1 and the table ends after at least one section, `entry_valid` is 1 and `entry_addr` is the destination address of the last section. When `gph_mode` is 0, `entry_valid` stays 0.
- R8: A table whose first word is zero raises `done` with `entry_valid` low and makes no writes.
- R9: A destination address with bits [1:0] not zero raises `error` and drops `in_ready`. No write is made for that section, and `done` stays low.
- R10: `done` and `error` stay high until reset.
- R11: Out of reset, `in_ready` is 1, and `wr_valid`, `done`, `error` and `entry_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gph_mode | input | 1 | 1 = report the entry point of the last section |
| swap_le | input | 1 | 1 = byte-swap payload for little-endian memory |
| in_data | input | 32 | Stream word |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high with in_valid |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Per-lane byte enables, lane k = wr_data[8k+7:8k] |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| done | output | 1 | Table terminator reached |
| error | output | 1 | Misaligned section address seen |
| entry_valid | output | 1 | entry_addr is meaningful |
| entry_addr | output | 32 | Base of the last section |

## Verification
The bench covers byte counts of every residue mod 4 under both byte orders. A wrong lane mask would clobber bytes past the end of a section, and an off-by-one on the remaining count would turn the following header into a payload write. Random-pattern write stalls check that a design which took stream words during a stall would drop or shift payload. A two-section table in both modes checks that the entry address is the last base and not the first. The empty-table and misaligned cases catch a design that reports a false entry point or writes to an unaligned address.

// File: rtl/boot_section_loader.sv
module boot_section_loader #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gph_mode,
  input  logic              swap_le,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_W/8-1:0] wr_be,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              done,
  output logic              error,
  output logic              entry_valid,
  output logic [WORD_W-1:0] entry_addr
);
  localparam int LANES = WORD_W / 8;
  localparam int LSB   = $clog2(LANES);

  typedef enum logic [2:0] {ST_COUNT, ST_ADDR, ST_DATA, ST_DONE, ST_FAULT} st_t;

  st_t               st;
  logic [WORD_W-1:0] remaining;
  logic [WORD_W-1:0] cur_addr;
  logic [WORD_W-1:0] last_base;
  logic              seen;
  logic [WORD_W-1:0] swapped;
  logic [LANES-1:0]  lead_lo;
  logic [LANES-1:0]  lead_hi;
  logic              partial;

  for (genvar g = 0; g < LANES; g++) begin : g_swap
    assign swapped[8*g +: 8] = in_data[WORD_W-8-8*g +: 8];
  end

  wire take = in_valid && in_ready;

  assign partial = remaining < WORD_W'(LANES);
  assign lead_lo = LANES'((1 << remaining[LSB-1:0]) - 1);
  assign lead_hi = ~({LANES{1'b1}} >> remaining[LSB-1:0]);

  always_comb begin
    case (st)
      ST_COUNT, ST_ADDR: in_ready = 1'b1;
      ST_DATA:           in_ready = wr_ready;
      default:           in_ready = 1'b0;
    endcase
  end

  assign wr_valid    = (st == ST_DATA) && in_valid;
  assign wr_addr     = cur_addr;
  assign wr_data     = swap_le ? swapped : in_data;
  assign wr_be       = !partial ? {LANES{1'b1}} : (swap_le ? lead_lo : lead_hi);
  assign done        = (st == ST_DONE);
  assign error       = (st == ST_FAULT);
  assign entry_valid = done && gph_mode && seen;
  assign entry_addr  = last_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_COUNT;
      remaining <= '0;
      cur_addr  <= '0;
      last_base <= '0;
      seen      <= 1'b0;
    end else begin
      case (st)
        ST_COUNT: if (take) begin
          if (in_data == '0) st <= ST_DONE;
          else begin
            remaining <= in_data;
            st        <= ST_ADDR;
          end
        end
        ST_ADDR: if (take) begin
          if (in_data[LSB-1:0] != '0) st <= ST_FAULT;
          else begin
            cur_addr  <= in_data;
            last_base <= in_data;
            seen      <= 1'b1;
            st        <= ST_DATA;
          end
        end
        ST_DATA: if (take) begin
          cur_addr <= cur_addr + WORD_W'(LANES);
          if (remaining <= WORD_W'(LANES)) begin
            remaining <= '0;
            st        <= ST_COUNT;
          end else begin
            remaining <= remaining - WORD_W'(LANES);
          end
        end
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/boot_section_loader_chk.sv
module boot_section_loader_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gph_mode,
  input logic              in_ready,
  input logic [WORD_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W/8-1:0] wr_be,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              done,
  input logic              error,
  input logic              entry_valid
);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));

  assert_stall_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !in_ready);

  assert_write_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00 && wr_be != '0);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  assert_done_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !wr_valid);

  assert_error_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !in_ready && !wr_valid && !done);

  assert_entry_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> done && gph_mode);
endmodule

bind boot_section_loader boot_section_loader_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/boot_section_loader_tb.sv
module boot_section_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gph_mode = 1'b0;
  logic        swap_le = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic        done, error, entry_valid;
  logic [31:0] entry_addr;

  always #4 clk = ~clk;

  boot_section_loader dut_i (
    .clk(clk), .rst_n(rst_n), .gph_mode(gph_mode), .swap_le(swap_le),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .done(done), .error(error),
    .entry_valid(entry_valid), .entry_addr(entry_addr)
  );

  int checks = 0;
  int fails = 0;
  int exp_n = 0;
  int got_n = 0;
  logic [31:0] exp_addr [0:255];
  logic [31:0] exp_data [0:255];
  logic [3:0]  exp_be   [0:255];
  logic        stall_en = 1'b0;
  int          cyc = 0;

  // count, addr, swap, gph, stall
  localparam logic [66:0] VEC [0:5] = '{
    {32'd8,  32'h0000_1000, 1'b1, 1'b1, 1'b0},
    {32'd5,  32'h0000_2000, 1'b1, 1'b0, 1'b0},
    {32'd6,  32'h0000_3000, 1'b0, 1'b1, 1'b1},
    {32'd7,  32'h0000_0400, 1'b1, 1'b1, 1'b1},
    {32'd1,  32'h0000_0010, 1'b0, 1'b0, 1'b0},
    {32'd13, 32'h8000_0000, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    wr_ready <= !stall_en || ((cyc % 3) != 0 && (cyc % 7) != 2);
  end

  always begin
    @(negedge clk);
    #1;
    if (wr_valid && wr_ready) begin
      if (got_n >= exp_n) check(1'b0, "R3 extra write", wr_addr, 32'hFFFF_FFFF);
      else begin
        check(wr_addr == exp_addr[got_n], "R3 wr_addr", wr_addr, exp_addr[got_n]);
        check(wr_data == exp_data[got_n], "R5 wr_data", wr_data, exp_data[got_n]);
        check(wr_be == exp_be[got_n], "R4 wr_be", {28'd0, wr_be}, {28'd0, exp_be[got_n]});
      end
      got_n++;
    end
  end

  task automatic send(input logic [31:0] w);
    logic acc;
    in_data  = w;
    in_valid = 1'b1;
    do begin
      #1;
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] payload(input int i);
    logic [7:0] b = 8'(i * 4 + 8'h31);
    return {b, b + 8'd1, b + 8'd2, b + 8'd3};
  endfunction

  task automatic section(input logic [31:0] cnt, input logic [31:0] addr, input logic sw);
    int words = (int'(cnt) + 3) / 4;
    send(cnt);
    send(addr);
    for (int i = 0; i < words; i++) begin
      logic [31:0] p = payload(i);
      int rem = int'(cnt) - 4 * i;
      exp_addr[exp_n] = addr + 32'(4 * i);
      exp_data[exp_n] = sw ? {p[7:0], p[15:8], p[23:16], p[31:24]} : p;
      if (rem >= 4) exp_be[exp_n] = 4'hF;
      else if (sw) exp_be[exp_n] = 4'((1 << rem) - 1);
      else exp_be[exp_n] = 4'((4'hF << (4 - rem)) & 4'hF);
      exp_n++;
      send(p);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    join_none

    do_reset();
    #1;
    check(in_ready && !wr_valid && !done && !error && !entry_valid, "R11 reset state",
          {27'd0, in_ready, wr_valid, done, error, entry_valid}, 32'h10);

    for (int v = 0; v < 6; v++) begin
      logic [66:0] e = VEC[v];
      do_reset();
      swap_le  = e[2];
      gph_mode = e[1];
      stall_en = e[0];
      section(e[66:35], e[34:3], e[2]);
      send(32'd0);
      #1;
      check(done && !in_ready, "R2 done after terminator", {30'd0, done, in_ready}, 32'h2);
      check(entry_valid == e[1], "R7 entry_valid", {31'd0, entry_valid}, {31'd0, e[1]});
      if (e[1]) check(entry_addr == e[34:3], "R7 entry_addr", entry_addr, e[34:3]);
      check(got_n == exp_n, "R3 write count", got_n, exp_n);
      check(!error, "R1 header accepted", {31'd0, error}, 32'd0);
      @(negedge clk);
    end

    // R7, R4: two sections, the partial first one, then the entry at the second base
    for (int m = 0; m < 2; m++) begin
      do_reset();
      swap_le = 1'b0;
      gph_mode = m[0];
      stall_en = 1'b1;
      section(32'd5, 32'h0000_5000, 1'b0);
      section(32'd4, 32'h0000_6000, 1'b0);
      send(32'd0);
      #1;
      check(entry_valid == m[0], "R7 mode gate", {31'd0, entry_valid}, {31'd0, m[0]});
      if (m[0]) check(entry_addr == 32'h0000_6000, "R7 last section base", entry_addr, 32'h0000_6000);
      check(got_n == exp_n, "R4 next header after partial", got_n, exp_n);
      @(negedge clk);
    end

    // R8: empty table
    do_reset();
    gph_mode = 1'b1;
    stall_en = 1'b0;
    send(32'd0);
    #1;
    check(done && !entry_valid, "R8 empty table", {30'd0, done, entry_valid}, 32'h2);
    repeat (5) @(negedge clk);
    #1;
    check(done && !in_ready, "R10 done sticky", {30'd0, done, in_ready}, 32'h2);
    check(got_n == exp_n, "R8 no writes", got_n, exp_n);

    // R9: misaligned address
    do_reset();
    send(32'd8);
    send(32'h0000_0102);
    in_data = 32'hDEAD_BEEF;
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(error && !in_ready && !done && !wr_valid, "R9 misaligned stops",
          {28'd0, error, in_ready, done, wr_valid}, 32'h8);
    check(got_n == exp_n, "R9 no write", got_n, exp_n);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(error, "R10 error sticky", {31'd0, error}, 32'd1);

    do_reset();
    #1;
    check(!error && in_ready, "R11 reset clears", {30'd0, error, in_ready}, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule